// File: doc/BRIEF.md
# Programmable Bus Wait-State Generator

This block sets the length of external bus cycles for a small number of memory areas. A configuration register holds a 4-bit wait code for each area. When a cycle request arrives, the block takes the code of the addressed area and turns it into a number of states. For a single access, the code sets the number of inserted wait states. For a burst, the same code sets the number of states in each data beat. The code-to-count curve is non-linear. It rises by one state per step for the low codes, then by two, then by four.

A single access has three parts: one setup state, the decoded wait states, and a closing data state. The data state pulses `ready` and `done`. A burst runs 1 to 8 beats. Each beat ends with a `ready` pulse, and `done` comes with the last one. An active-low `wait_n` input can stretch a cycle one clock at a time. For single accesses this only happens when the code is nonzero. For bursts it happens for every code.

The code and the burst settings are captured when the cycle starts, so a register write during a cycle only affects later cycles. A flag reports a wait code whose top bit is set in an area that is not marked for card-interface use.

Top module: `bus_wait_gen`

## Requirements
- R1: Single access with code c. The inserted wait count N(c) is: c for c = 0..4, 2c-4 for c = 5..9, and 4c-22 for c = 10..15. This gives 0,1,2,3,4,6,8,10,12,14,18,22,26,30,34,38. The cycle begins with one setup state in the clock after the accepting edge. The N wait states follow, then one data state in which `ready` and `done` are both 1. With `wait_n` high the whole cycle is N+2 clocks long.
- R2: For a single access with code 0, `wait_n` is ignored. The cycle lasts 2 clocks whatever `wait_n` does.
- R3: For a single access with a nonzero code, `wait_n` is sampled at the end of the last wait state. While it is seen low, one more wait state is added per clock. The data state follows the first wait state that ends with `wait_n` high.
- R4: Burst access with code c. Each beat lasts P(c) states: P(0) = 2, and P(c) = N(c)+1 otherwise. This gives 2,2,3,4,5,7,9,11,13,15,19,23,27,31,35,39. The burst has `beats_m1`+1 beats. The first beat begins in the clock after the accepting edge, and there is no setup state. `ready` is 1 in the last state of each beat. `done` is 1 together with the final `ready`. With `wait_n` high the burst is (`beats_m1`+1)·P clocks long.
- R5: In a burst, `wait_n` is honoured for every code, including 0. A beat whose last state sees `wait_n` low gives no `ready` and repeats that state each clock until `wait_n` is high.
- R6: Each area has its own independent code. All areas use the same mapping. `area_sel` picks the code used by a cycle (0 = area 0, 1 = area 1).
- R7: Configuration register layout:
  - bits [3:0] hold the area-0 code;
  - bits [7:4] hold the area-1 code;
  - bit 8 is the area-0 card-interface mark;
  - bit 9 is the area-1 card-interface mark;
  - bits [11:10] are reserved. They always read 0, and writes to them change nothing.

  A write with `cfg_we` high takes effect at the clock edge. `cfg_rdata` shows the register with no delay. The reset value is 12'h077 (both codes 7, no card marks).
- R8: `cfg_err` is 1 exactly when some area has bit 3 of its code set while its card-interface mark is 0.
- R9: The code and burst settings are captured at the edge that accepts a request. A register write during an active cycle does not change that cycle's length. It does apply to the next cycle.
- R10: A request is accepted only while `busy` is 0. `busy` is 1 from the clock after acceptance up to and including the `done` clock. A `req` during a busy cycle is dropped and starts no cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_wdata | input | 12 | Configuration write data |
| cfg_rdata | output | 12 | Configuration register readback |
| cfg_err | output | 1 | Illegal top code bit outside card-interface mode |
| req | input | 1 | Cycle request, accepted while idle |
| area_sel | input | 1 | Area addressed by the request |
| burst | input | 1 | 1 = burst cycle, 0 = single access |
| beats_m1 | input | 3 | Burst beat count minus one |
| wait_n | input | 1 | Active-low external wait |
| busy | output | 1 | Cycle in progress |
| ready | output | 1 | End of a data beat |
| done | output | 1 | Cycle finished |

## Verification
The bench builds the block with its defaults: two areas and up to eight beats. This brings both area codes, the 8-beat burst and the longest 39-state beat within reach. The vectors cover every segment of the non-linear curve, and each segment appears in both single and burst form. They hold `wait_n` low across the sampling state of both kinds of cycle, including code 0, where only the burst reacts. Directed tests rewrite the register in the middle of a cycle and send a request while the block is busy.

// File: rtl/bwg_pkg.sv
package bwg_pkg;

    localparam int CODE_W = 4;
    localparam int CNT_W  = 6;
    localparam int RSV_W  = 2;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_WAITS,
        ST_DATA,
        ST_BEAT
    } seq_state_e;

    typedef struct packed {
        code_t code;
        logic  burst;
    } xfer_cfg_t;

    // Inserted wait states of a single access: slope 1, then 2, then 4.
    function automatic cnt_t single_waits(input code_t c);
        cnt_t v;
        v = cnt_t'(c);
        if (c <= 4'd4)
            return v;
        else if (c <= 4'd9)
            return cnt_t'((v << 1) - cnt_t'(4));
        else
            return cnt_t'((v << 2) - cnt_t'(22));
    endfunction

    // States per burst beat: one more than the single wait count, floor of two.
    function automatic cnt_t beat_states(input code_t c);
        if (c == '0)
            return cnt_t'(2);
        else
            return cnt_t'(single_waits(c) + cnt_t'(1));
    endfunction

    function automatic logic wait_honoured(input xfer_cfg_t x);
        return x.burst || (x.code != '0);
    endfunction

endpackage

// File: rtl/bwg_cfg_regs.sv
module bwg_cfg_regs
    import bwg_pkg::*;
#(
    parameter int NUM_AREAS = 2,
    localparam int CARD_LSB = NUM_AREAS * CODE_W,
    localparam int RSV_LSB  = CARD_LSB + NUM_AREAS,
    localparam int REG_W    = RSV_LSB + RSV_W
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             we,
    input  logic [REG_W-1:0]                 wdata,
    output logic [REG_W-1:0]                 rdata,
    output logic [NUM_AREAS-1:0][CODE_W-1:0] codes,
    output logic                             err
);

    localparam code_t CODE_RST = code_t'(7);

    logic [NUM_AREAS-1:0] card_q;

    for (genvar a = 0; a < NUM_AREAS; a++) begin : g_area
        always_ff @(posedge clk) begin
            if (rst) begin
                codes[a]  <= CODE_RST;
                card_q[a] <= 1'b0;
            end else if (we) begin
                codes[a]  <= wdata[a*CODE_W +: CODE_W];
                card_q[a] <= wdata[CARD_LSB + a];
            end
        end

        assign rdata[a*CODE_W +: CODE_W] = codes[a];
        assign rdata[CARD_LSB + a]       = card_q[a];

        // An illegal top bit written without the card mark raises the flag.
        assert_err_flag_R8 : assert property (@(posedge clk) disable iff (rst)
            (we && wdata[a*CODE_W + CODE_W - 1] && !wdata[CARD_LSB + a]) |=> err);
    end

    assign rdata[REG_W-1:RSV_LSB] = '0;

    always_comb begin
        err = 1'b0;
        for (int a = 0; a < NUM_AREAS; a++) begin
            if (codes[a][CODE_W-1] && !card_q[a])
                err = 1'b1;
        end
    end

    // Reserved write bits leave no trace; the code fields take the written value.
    assert_rsv_ignored_R7 : assert property (@(posedge clk) disable iff (rst)
        (we && (wdata[REG_W-1:RSV_LSB] != '0))
        |=> (rdata[RSV_LSB-1:0] == $past(wdata[RSV_LSB-1:0])));

endmodule

// File: rtl/bwg_code_sel.sv
module bwg_code_sel
    import bwg_pkg::*;
#(
    parameter int NUM_AREAS = 2,
    localparam int SEL_W    = (NUM_AREAS > 1) ? $clog2(NUM_AREAS) : 1
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             start,
    input  logic                             busy,
    input  logic [SEL_W-1:0]                 area_sel,
    input  logic                             burst_in,
    input  logic [NUM_AREAS-1:0][CODE_W-1:0] codes,
    output cnt_t                             limit,
    output logic                             honour
);

    xfer_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (start) begin
            cfg_q.code  <= codes[area_sel];
            cfg_q.burst <= burst_in;
        end
    end

    always_comb begin
        if (cfg_q.burst)
            limit = beat_states(cfg_q.code);
        else
            limit = single_waits(cfg_q.code);
        honour = wait_honoured(cfg_q);
    end

    // The captured setting holds for the whole of a running cycle.
    assert_code_stable_R9 : assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cfg_q));

endmodule

// File: rtl/bwg_seq.sv
module bwg_seq
    import bwg_pkg::*;
#(
    parameter int MAX_BEATS = 8,
    localparam int BEAT_W   = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              burst_in,
    input  logic [BEAT_W-1:0] beats_m1_in,
    input  logic              wait_n,
    input  cnt_t              limit,
    input  logic              honour,
    output logic              start,
    output logic              busy,
    output logic              ready,
    output logic              done
);

    seq_state_e        state;
    cnt_t              cnt;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] beats_q;
    cnt_t              last;
    logic              at_last;
    logic              stall;
    logic              beat_go;

    always_comb begin
        last    = cnt_t'(limit - cnt_t'(1));
        at_last = (cnt == last);
        stall   = honour && !wait_n;
        beat_go = (state == ST_BEAT) && at_last && !stall;
        start   = req && (state == ST_IDLE);
        busy    = (state != ST_IDLE);
        ready   = (state == ST_DATA) || beat_go;
        done    = (state == ST_DATA) || (beat_go && (beat == beats_q));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            beat    <= '0;
            beats_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req) begin
                        cnt     <= '0;
                        beat    <= '0;
                        beats_q <= beats_m1_in;
                        state   <= burst_in ? ST_BEAT : ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    cnt   <= '0;
                    state <= (limit == '0) ? ST_DATA : ST_WAITS;
                end
                ST_WAITS: begin
                    if (at_last) begin
                        if (!stall)
                            state <= ST_DATA;
                    end else begin
                        cnt <= cnt + cnt_t'(1);
                    end
                end
                ST_DATA: begin
                    state <= ST_IDLE;
                end
                ST_BEAT: begin
                    if (at_last) begin
                        if (!stall) begin
                            cnt <= '0;
                            if (beat == beats_q)
                                state <= ST_IDLE;
                            else
                                beat <= beat + 1'b1;
                        end
                    end else begin
                        cnt <= cnt + cnt_t'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // The data state is reached only through setup or wait states.
    assert_data_after_wait_R1 : assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA) |-> ($past(state) == ST_SETUP || $past(state) == ST_WAITS));

    // A low wait at the end of the last wait state keeps the cycle waiting.
    assert_wait_stretch_R3 : assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAITS && at_last && honour && !wait_n) |=> (state == ST_WAITS));

    // A burst beat never completes while wait is low.
    assert_burst_hold_R5 : assert property (@(posedge clk) disable iff (rst)
        (state == ST_BEAT && !wait_n) |-> !ready);

    // Completion is always marked by a ready pulse.
    assert_done_ready_R4 : assert property (@(posedge clk) disable iff (rst)
        done |-> ready);

    // A running cycle cannot be dropped or restarted before it is done.
    assert_busy_hold_R10 : assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen
    import bwg_pkg::*;
#(
    parameter int NUM_AREAS = 2,
    parameter int MAX_BEATS = 8,
    localparam int SEL_W    = (NUM_AREAS > 1) ? $clog2(NUM_AREAS) : 1,
    localparam int BEAT_W   = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1,
    localparam int REG_W    = NUM_AREAS * (CODE_W + 1) + RSV_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    output logic              cfg_err,
    input  logic              req,
    input  logic [SEL_W-1:0]  area_sel,
    input  logic              burst,
    input  logic [BEAT_W-1:0] beats_m1,
    input  logic              wait_n,
    output logic              busy,
    output logic              ready,
    output logic              done
);

    logic [NUM_AREAS-1:0][CODE_W-1:0] codes;
    cnt_t                             limit;
    logic                             honour;
    logic                             start;

    bwg_cfg_regs #(
        .NUM_AREAS(NUM_AREAS)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .codes (codes),
        .err   (cfg_err)
    );

    bwg_code_sel #(
        .NUM_AREAS(NUM_AREAS)
    ) u_sel (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .busy     (busy),
        .area_sel (area_sel),
        .burst_in (burst),
        .codes    (codes),
        .limit    (limit),
        .honour   (honour)
    );

    bwg_seq #(
        .MAX_BEATS(MAX_BEATS)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .burst_in    (burst),
        .beats_m1_in (beats_m1),
        .wait_n      (wait_n),
        .limit       (limit),
        .honour      (honour),
        .start       (start),
        .busy        (busy),
        .ready       (ready),
        .done        (done)
    );

endmodule

// File: tb/sim_bus_wait_gen.sv
`timescale 1ns/1ps
module sim_bus_wait_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_wdata = '0;
    logic [11:0] cfg_rdata;
    logic        cfg_err;
    logic        req = 1'b0;
    logic        area_sel = 1'b0;
    logic        burst = 1'b0;
    logic [2:0]  beats_m1 = '0;
    logic        wait_n = 1'b1;
    logic        busy;
    logic        ready;
    logic        done;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    bus_wait_gen u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cfg_err(cfg_err), .req(req),
        .area_sel(area_sel), .burst(burst), .beats_m1(beats_m1),
        .wait_n(wait_n), .busy(busy), .ready(ready), .done(done)
    );

    typedef struct packed {
        logic [3:0] code;
        logic       area;
        logic       bst;
        logic [2:0] bm1;
        logic [7:0] hold;
        logic [7:0] exp_len;
        logic [3:0] exp_rdy;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{4'd0,  1'b0, 1'b0, 3'd0, 8'd0, 8'd2,  4'd1},
        '{4'd0,  1'b0, 1'b0, 3'd0, 8'd5, 8'd2,  4'd1},
        '{4'd1,  1'b0, 1'b0, 3'd0, 8'd0, 8'd3,  4'd1},
        '{4'd5,  1'b0, 1'b0, 3'd0, 8'd0, 8'd8,  4'd1},
        '{4'd9,  1'b1, 1'b0, 3'd0, 8'd0, 8'd16, 4'd1},
        '{4'd15, 1'b1, 1'b0, 3'd0, 8'd0, 8'd40, 4'd1},
        '{4'd3,  1'b0, 1'b0, 3'd0, 8'd8, 8'd10, 4'd1},
        '{4'd0,  1'b0, 1'b1, 3'd0, 8'd0, 8'd2,  4'd1},
        '{4'd0,  1'b1, 1'b1, 3'd0, 8'd3, 8'd4,  4'd1},
        '{4'd2,  1'b0, 1'b1, 3'd3, 8'd0, 8'd12, 4'd4},
        '{4'd7,  1'b1, 1'b1, 3'd7, 8'd0, 8'd88, 4'd8},
        '{4'd15, 1'b0, 1'b1, 3'd1, 8'd0, 8'd78, 4'd2},
        '{4'd10, 1'b1, 1'b0, 3'd0, 8'd0, 8'd20, 4'd1},
        '{4'd4,  1'b0, 1'b0, 3'd0, 8'd6, 8'd8,  4'd1},
        '{4'd12, 1'b0, 1'b1, 3'd2, 8'd0, 8'd81, 4'd3}
    };

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Issue one cycle and count its length in clocks, its readies and dones.
    task automatic run_cycle(input logic a, input logic b, input logic [2:0] bm,
                             input int hold, input logic mid_wr,
                             input logic [11:0] mid_data, input logic poke_req,
                             output int len, output int rdy, output int dn);
        int c;
        @(negedge clk);
        req = 1'b1; area_sel = a; burst = b; beats_m1 = bm; wait_n = 1'b1;
        @(negedge clk);
        req = 1'b0;
        len = 0; rdy = 0; dn = 0;
        c = 1;
        while (c < 400) begin
            wait_n = (hold != 0 && c <= hold) ? 1'b0 : 1'b1;
            if (mid_wr) begin
                cfg_we = (c == 1);
                cfg_wdata = mid_data;
            end
            if (poke_req) req = (c == 2);
            #1;
            if (ready) rdy++;
            if (done) begin
                dn++;
                len = c;
                break;
            end
            @(negedge clk);
            c++;
        end
        cfg_we = 1'b0;
        req = 1'b0;
        wait_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int len, rdy, dn;
        string tag;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // Reset state
        chk("R7 reset rdata", int'(cfg_rdata), 'h077);
        chk("R8 reset err", int'(cfg_err), 0);
        chk("R10 reset busy", int'(busy), 0);
        chk("R1 reset ready", int'(ready), 0);
        chk("R4 reset done", int'(done), 0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            logic [11:0] d;
            d = 12'hF00;
            if (VEC[i].area) d[7:4] = VEC[i].code;
            else             d[3:0] = VEC[i].code;
            wr(d);
            run_cycle(VEC[i].area, VEC[i].bst, VEC[i].bm1, int'(VEC[i].hold),
                      1'b0, 12'h0, 1'b0, len, rdy, dn);
            if (VEC[i].bst) tag = (VEC[i].hold != 0) ? "R5" : "R4";
            else if (VEC[i].hold != 0) tag = (VEC[i].code == 0) ? "R2" : "R3";
            else tag = "R1";
            chk($sformatf("%s vec%0d length", tag, i), len, int'(VEC[i].exp_len));
            chk($sformatf("%s vec%0d readies", tag, i), rdy, int'(VEC[i].exp_rdy));
            chk($sformatf("%s vec%0d dones", tag, i), dn, 1);
            @(negedge clk); #1;
            chk($sformatf("R10 vec%0d idle after", i), int'(busy), 0);
        end

        // Reserved bits: written as ones, read back as zero
        wr(12'hFFF);
        #1;
        chk("R7 reserved read zero", int'(cfg_rdata), 'h3FF);
        chk("R8 card marks allow top bit", int'(cfg_err), 0);

        // Configuration error flag
        wr(12'h008);
        #1;
        chk("R8 area0 illegal", int'(cfg_err), 1);
        wr(12'h108);
        #1;
        chk("R8 area0 card ok", int'(cfg_err), 0);
        wr(12'h190);
        #1;
        chk("R8 area1 illegal", int'(cfg_err), 1);

        // Independent areas
        wr(12'h3A1);
        #1;
        chk("R6 readback", int'(cfg_rdata), 'h3A1);
        run_cycle(1'b0, 1'b0, 3'd0, 0, 1'b0, 12'h0, 1'b0, len, rdy, dn);
        chk("R6 area0 length", len, 3);
        run_cycle(1'b1, 1'b0, 3'd0, 0, 1'b0, 12'h0, 1'b0, len, rdy, dn);
        chk("R6 area1 length", len, 20);

        // Mid-cycle write applies to the next cycle only
        wr(12'h302);
        run_cycle(1'b0, 1'b0, 3'd0, 0, 1'b1, 12'h30F, 1'b0, len, rdy, dn);
        chk("R9 current cycle length", len, 4);
        #1;
        chk("R9 write landed", int'(cfg_rdata), 'h30F);
        run_cycle(1'b0, 1'b0, 3'd0, 0, 1'b0, 12'h0, 1'b0, len, rdy, dn);
        chk("R9 next cycle length", len, 40);

        // Request while busy is dropped
        wr(12'h302);
        run_cycle(1'b0, 1'b0, 3'd0, 0, 1'b0, 12'h0, 1'b1, len, rdy, dn);
        chk("R10 poked cycle length", len, 4);
        dn = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); #1;
            if (busy || done) dn++;
        end
        chk("R10 no extra cycle", dn, 0);

        // Burst code 0 honours wait in a later beat pattern
        wr(12'h300);
        run_cycle(1'b0, 1'b1, 3'd2, 5, 1'b0, 12'h0, 1'b0, len, rdy, dn);
        chk("R5 code0 burst length", len, 10);
        chk("R5 code0 burst readies", rdy, 3);

        summary();
        $finish;
    end

endmodule